// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It does this by reading a three-level translation table that lives in physical memory. A client hands over the virtual address together with the physical base of the root table. The walker then issues one 32-bit read per level on a valid/ready request port and takes each answer from a valid-qualified response port. When the walk ends it produces a one-cycle completion pulse. The pulse carries either the translated address or a fault that names the level where the walk stopped.

The first and second levels hold pointers to tables that are 2 KB long, which is half a page. Those pointers are 25 bits wide and are scaled by 2 KB. The last level holds a 24-bit frame number that is scaled by 4 KB. Each level therefore uses its own shift amount when it turns an entry into an address. The walker runs one translation at a time and accepts new work only while it is idle.

Top module: `pt_walk_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `req_ready` is 1, and `mem_req_valid` and `done` are 0.
- R2: The first read address is the root value with its low 4 bits forced to zero, plus 4 times virtual bits 31:30.
- R3: The second read address is entry-one bits 24:0 shifted left by 11, plus 4 times virtual bits 29:21. The third read address is entry-two bits 24:0 shifted left by 11, plus 4 times virtual bits 20:12.
- R4: A walk whose three entries are all valid ends with `done_fault`=0 and `done_level`=0. Its `done_paddr` equals entry-three bits 23:0 shifted left by 12, OR-ed with virtual bits 11:0.
- R5: Entry bit 31 is the valid flag. If that bit is 0 at level N, the walk ends with `done_fault`=1 and `done_level`=N (1, 2 or 3), and no further read is issued.
- R6: Entry bits 30:25 in the upper levels and bits 30:24 in the last level have no effect on any address or result.
- R7: Once raised, `mem_req_valid` stays high and `mem_req_addr` stays unchanged until the cycle in which `mem_req_ready` is seen high.
- R8: The response may arrive any number of cycles after acceptance. Each walk raises `done` for exactly one cycle.
- R9: `req_ready` is 1 only when no walk is in progress. A `req_valid` that arrives while a walk is busy is ignored.
- R10: In the cycle where `done` is presented, `req_ready` is 1, so a new request can be taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 36 | Physical base of the first-level table |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 36 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word read back |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk stopped on an invalid entry |
| done_level | output | 2 | Failing level 1..3, or 0 on success |
| done_paddr | output | 36 | Translated physical address |

## Verification
Two events can fall in the same cycle: the completion pulse of one walk and the acceptance of the next request. The bench provokes this by presenting each new request in the very cycle where the previous `done` is visible. It then judges both sides. It checks the finished walk's result and checks that `req_ready` is high in that cycle. It also checks that the new walk's first read address matches the new virtual address and root, and that `done` has dropped one cycle later. Random stalls on the memory port, random response latencies and stray requests during busy walks are mixed with the back-to-back case.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ptw_state_t;

  localparam logic [1:0] LVL_TOP  = 2'd1;
  localparam logic [1:0] LVL_LEAF = 2'd3;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 36,
  parameter int PTE_W    = 32,
  parameter int OFF_BITS = 12,
  parameter int L1_BITS  = 2,
  parameter int L2_BITS  = 9,
  parameter int L3_BITS  = 9
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      level,
  input  logic [PA_W-1:0] base,
  output logic [PA_W-1:0] entry_addr
);
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);
  localparam int L3_LSB      = OFF_BITS;
  localparam int L2_LSB      = OFF_BITS + L3_BITS;
  localparam int L1_LSB      = L2_LSB + L2_BITS;

  logic [PA_W-1:0] index;

  always_comb begin
    case (level)
      2'd1:    index = PA_W'(vaddr[L1_LSB +: L1_BITS]);
      2'd2:    index = PA_W'(vaddr[L2_LSB +: L2_BITS]);
      default: index = PA_W'(vaddr[L3_LSB +: L3_BITS]);
    endcase
    entry_addr = base + (index << ENTRY_SHIFT);
  end
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
  parameter int PA_W        = 36,
  parameter int PTE_W       = 32,
  parameter int VALID_BIT   = 31,
  parameter int PTR_W       = 25,
  parameter int CHUNK_SHIFT = 11,
  parameter int PFN_W       = 24,
  parameter int OFF_BITS    = 12
) (
  input  logic [PTE_W-1:0] entry,
  output logic             valid,
  output logic [PA_W-1:0]  table_base,
  output logic [PA_W-1:0]  frame_base
);
  always_comb begin
    valid      = entry[VALID_BIT];
    table_base = PA_W'(entry[PTR_W-1:0]) << CHUNK_SHIFT;
    frame_base = PA_W'(entry[PFN_W-1:0]) << OFF_BITS;
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 36,
  parameter int OFF_BITS   = 12,
  parameter int ROOT_ALIGN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [PA_W-1:0] req_root,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic            ent_valid,
  input  logic [PA_W-1:0] ent_table_base,
  input  logic [PA_W-1:0] ent_frame_base,
  output logic [VA_W-1:0] calc_vaddr,
  output logic [1:0]      calc_level,
  output logic [PA_W-1:0] calc_base,
  input  logic [PA_W-1:0] calc_addr,
  output logic            done,
  output logic            done_fault,
  output logic [1:0]      done_level,
  output logic [PA_W-1:0] done_paddr
);
  ptw_state_t      state_q;
  logic [VA_W-1:0] vaddr_q;
  logic [1:0]      level_q;
  logic            accept;

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    accept     = req_ready && req_valid;
    calc_vaddr = accept ? req_vaddr : vaddr_q;
    calc_level = accept ? LVL_TOP : level_q + 2'd1;
    calc_base  = accept ? {req_root[PA_W-1:ROOT_ALIGN], {ROOT_ALIGN{1'b0}}}
                        : ent_table_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      vaddr_q       <= '0;
      level_q       <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      done          <= 1'b0;
      done_fault    <= 1'b0;
      done_level    <= '0;
      done_paddr    <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            vaddr_q       <= req_vaddr;
            level_q       <= LVL_TOP;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= calc_addr;
            state_q       <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_valid) begin
              done       <= 1'b1;
              done_fault <= 1'b1;
              done_level <= level_q;
              done_paddr <= '0;
              state_q    <= ST_IDLE;
            end else if (level_q == LVL_LEAF) begin
              done       <= 1'b1;
              done_fault <= 1'b0;
              done_level <= 2'd0;
              done_paddr <= ent_frame_base | PA_W'(vaddr_q[OFF_BITS-1:0]);
              state_q    <= ST_IDLE;
            end else begin
              level_q       <= calc_level;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= calc_addr;
              state_q       <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walk_top.sv
module pt_walk_top #(
  parameter int VA_W        = 32,
  parameter int PA_W        = 36,
  parameter int PTE_W       = 32,
  parameter int OFF_BITS    = 12,
  parameter int L1_BITS     = 2,
  parameter int L2_BITS     = 9,
  parameter int L3_BITS     = 9,
  parameter int VALID_BIT   = 31,
  parameter int PTR_W       = 25,
  parameter int CHUNK_SHIFT = 11,
  parameter int PFN_W       = 24,
  parameter int ROOT_ALIGN  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  req_root,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             done_fault,
  output logic [1:0]       done_level,
  output logic [PA_W-1:0]  done_paddr
);
  logic            ent_valid;
  logic [PA_W-1:0] ent_table_base;
  logic [PA_W-1:0] ent_frame_base;
  logic [VA_W-1:0] calc_vaddr;
  logic [1:0]      calc_level;
  logic [PA_W-1:0] calc_base;
  logic [PA_W-1:0] calc_addr;

  ptw_entry_dec #(
    .PA_W(PA_W), .PTE_W(PTE_W), .VALID_BIT(VALID_BIT), .PTR_W(PTR_W),
    .CHUNK_SHIFT(CHUNK_SHIFT), .PFN_W(PFN_W), .OFF_BITS(OFF_BITS)
  ) u_dec (
    .entry(mem_rsp_data), .valid(ent_valid),
    .table_base(ent_table_base), .frame_base(ent_frame_base)
  );

  ptw_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .OFF_BITS(OFF_BITS),
    .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .L3_BITS(L3_BITS)
  ) u_agen (
    .vaddr(calc_vaddr), .level(calc_level), .base(calc_base),
    .entry_addr(calc_addr)
  );

  ptw_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_BITS(OFF_BITS), .ROOT_ALIGN(ROOT_ALIGN)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .ent_valid(ent_valid), .ent_table_base(ent_table_base),
    .ent_frame_base(ent_frame_base),
    .calc_vaddr(calc_vaddr), .calc_level(calc_level),
    .calc_base(calc_base), .calc_addr(calc_addr),
    .done(done), .done_fault(done_fault),
    .done_level(done_level), .done_paddr(done_paddr)
  );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            done,
  input logic            done_fault,
  input logic [1:0]      done_level
);
  a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_idle_no_read: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);

  a_r10_ready_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  a_r5_fault_level: assert property (@(posedge clk) disable iff (rst)
    (done && done_fault) |-> (done_level != 2'd0 && !mem_req_valid));

  a_r4_ok_level: assert property (@(posedge clk) disable iff (rst)
    (done && !done_fault) |-> (done_level == 2'd0));
endmodule

bind pt_walk_top ptw_chk #(.PA_W(PA_W)) i_ptw_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done),
  .done_fault(done_fault), .done_level(done_level)
);

// File: tb/test_pt_walk_top.sv
module test_pt_walk_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [35:0] req_root = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [35:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic        done_fault;
  logic [1:0]  done_level;
  logic [35:0] done_paddr;

  int n_checks = 0;
  int n_errors = 0;
  int n_done   = 0;
  int n_walks  = 0;
  int cycles   = 0;

  pt_walk_top i_pt_walk_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
    .done_level(done_level), .done_paddr(done_paddr)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst && done) n_done <= n_done + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [35:0] act,
                     input logic [35:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  function automatic [35:0] addr_l1(input [31:0] va, input [35:0] root);
    return {root[35:4], 4'b0} + 36'(va[31:30]) * 4;
  endfunction

  function automatic [35:0] addr_lo(input [24:0] ptr, input [8:0] idx);
    return (36'(ptr) << 11) + 36'(idx) * 4;
  endfunction

  task automatic serve(input [35:0] exp_addr, input [31:0] word, input int stall,
                       input int lat, input bit poke, input string rq);
    int guard = 0;
    while (!mem_req_valid && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    chk(mem_req_valid, rq, 36'(mem_req_valid), 36'd1);
    chk(mem_req_addr == exp_addr, rq, mem_req_addr, exp_addr);
    for (int i = 0; i < stall; i++) begin
      if (poke) begin
        req_valid = 1'b1;
        req_vaddr = $urandom;
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_req_valid && mem_req_addr == exp_addr, "R7 hold", mem_req_addr, exp_addr);
      if (poke) chk(!req_ready, "R9 busy", 36'(req_ready), 36'd0);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int i = 0; i < lat; i++) begin
      if (poke) req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = word;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = $urandom;
  endtask

  // Starts at a negedge with the walker idle; ends at the negedge where done shows.
  task automatic run_walk(input [31:0] va, input [35:0] root, input [24:0] p1,
                          input [24:0] p2, input [23:0] pfn, input int flvl,
                          input [6:0] junk, input int stall, input int lat,
                          input bit poke);
    logic [31:0] e1, e2, e3;
    logic [35:0] exp_pa;
    e1 = {flvl != 1, junk[5:0], p1};
    e2 = {flvl != 2, junk[6:1], p2};
    e3 = {flvl != 3, junk, pfn};
    exp_pa = (36'(pfn) << 12) | 36'(va[11:0]);
    chk(req_ready, "R10 ready", 36'(req_ready), 36'd1);
    req_valid = 1'b1;
    req_vaddr = va;
    req_root  = root;
    @(negedge clk);
    req_valid = 1'b0;
    req_root  = $urandom;
    n_walks++;
    chk(!done, "R8 one-cycle", 36'(done), 36'd0);
    serve(addr_l1(va, root), e1, stall, lat, poke, "R2 L1 addr");
    if (flvl != 1) serve(addr_lo(p1, va[29:21]), e2, stall, lat, poke, "R3 L2 addr");
    if (flvl != 1 && flvl != 2) serve(addr_lo(p2, va[20:12]), e3, stall, lat, poke, "R3 L3 addr");
    chk(done, "R8 done", 36'(done), 36'd1);
    if (flvl == 0) begin
      chk(!done_fault && done_level == 2'd0, "R4 ok flags", {33'd0, done_fault, done_level}, 36'd0);
      chk(done_paddr == exp_pa, "R4 R6 paddr", done_paddr, exp_pa);
    end else begin
      chk(done_fault && done_level == 2'(flvl), "R5 fault level",
          {33'd0, done_fault, done_level}, {33'd0, 1'b1, 2'(flvl)});
      chk(!mem_req_valid, "R5 no more reads", 36'(mem_req_valid), 36'd0);
    end
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !done, "R1 in reset",
        {33'd0, req_ready, mem_req_valid, done}, 36'h4);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready && !mem_req_valid && !done, "R1 after reset",
        {33'd0, req_ready, mem_req_valid, done}, 36'h4);

    // Directed corners
    run_walk(32'hFFFF_FFFF, 36'hF_FFFF_FFFF, 25'h1FF_FFFF, 25'h1FF_FFFF, 24'hFF_FFFF, 0, 7'h7F, 0, 0, 0);
    run_walk(32'h0000_0000, 36'h0_0000_000F, 25'h0, 25'h0, 24'h0, 0, 7'h7F, 0, 0, 0);
    run_walk(32'h8020_1ABC, 36'h1_2345_6780, 25'h0ABCDE, 25'h155555, 24'hC0FFEE, 0, 7'h00, 2, 3, 1);
    run_walk(32'h4000_0123, 36'h0_0000_1000, 25'h12345, 25'h0, 24'h0, 1, 7'h55, 1, 1, 0);
    run_walk(32'hC1234567, 36'h2_0000_0000, 25'h1ABCD, 25'h0, 24'h0, 2, 7'h2A, 0, 2, 1);
    run_walk(32'h7FFF_F000, 36'h3_3333_3330, 25'h00F0F, 25'h1F0F0, 24'h0, 3, 7'h7F, 3, 0, 0);

    // Random walks, back to back
    for (int n = 0; n < 80; n++) begin
      int f;
      f = ($urandom % 4 == 0) ? int'($urandom % 3) + 1 : 0;
      run_walk($urandom, {$urandom, $urandom}[35:0], 25'($urandom), 25'($urandom),
               24'($urandom), f, 7'($urandom), int'($urandom % 4),
               int'($urandom % 5), 1'($urandom));
    end

    @(negedge clk);
    chk(!done, "R8 one-cycle", 36'(done), 36'd0);
    repeat (3) @(negedge clk);
    chk(n_done == n_walks, "R8 pulse count", 36'(n_done), 36'(n_walks));
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule